// File: doc/BRIEF.md
# Per-Entry Page-Size Translation Lookup

This block is a combinational, fully associative address-translation lookup. It compares a 32-bit virtual address against a set of translation entries at once. Each entry has its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space tag, a shared flag, two protection bits and a dirty bit. For the access presented, the block returns the translated physical address, the permissions that the matching entry grants, or one fault code.

The block does not load entries, choose entries to replace or sequence exceptions. The entry array comes in on ports from the storage that owns it. The requester supplies the current address-space tag, the privilege level, a single-address-space mode bit and the access kind. Access kinds are encoded `2'b00` read, `2'b01` write and `2'b10` instruction fetch. Only `2'b01` counts as a write.

Top module: `tlbc_lookup`

## Requirements
- R1: An entry's page span is its VPN placed above 10 zero bits, with the low offset bits cleared. The size codes give the number of offset bits: 0 gives 10, 1 gives 12, 2 gives 16 and 3 gives 20. A valid entry covers every address whose bits above the offset width equal those of the span. An invalid entry matches nothing.
- R2: A non-shared entry matches only when its tag equals the current tag, provided tag checking is on. A shared entry matches whatever its tag is.
- R3: Tag checking is off only when the single-address-space bit and the privileged bit are both 1. In every other combination it is on.
- R4: When two or more entries match, fault_o is 0x140, match_o shows every matching entry and hit_o is 0.
- R5: On a fault-free hit, pa_o takes its offset bits from the virtual address. The bits above the offset come from the matching entry's PPN with 10 zero bits appended.
- R6: When no entry matches, fault_o is 0x060 for a write and 0x040 for a read or fetch. Fault code 0 means no fault.
- R7: When privileged is 0 and the matching entry has protection bit 1 clear, the lookup faults with 0x0A0 for a read or fetch and 0x0C0 for a write. This check takes priority over R8.
- R8: When the R7 check passes, a write to an entry with protection bit 0 clear faults with 0x0C0. A write to an entry with protection bit 0 set and dirty 0 faults with 0x080. The write-protect check takes priority over the dirty check.
- R9: perm_o is {execute, write, read}. On a fault-free hit, read is 1, execute equals (access is fetch), and write equals protection bit 0 AND dirty.
- R10: When fault_o is non-zero, pa_o and perm_o are zero. hit_o is 1 exactly when one entry matches, and hit_idx_o then gives that entry's position. Otherwise hit_idx_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| va_i | input | 32 | Virtual address |
| cur_asid_i | input | ASID_W | Current address-space tag |
| priv_i | input | 1 | Privileged mode |
| sv_mode_i | input | 1 | Single-address-space mode |
| ent_valid_i | input | N | Entry valid flags |
| ent_shared_i | input | N | Entry shared flags |
| ent_asid_i | input | N x ASID_W | Entry tags |
| ent_vpn_i | input | N x 22 | Entry virtual page numbers (address bits 31:10) |
| ent_ppn_i | input | N x (PA_W-10) | Entry physical page numbers |
| ent_size_i | input | N x 2 | Entry size codes |
| ent_prot_i | input | N x 2 | Entry protection bits |
| ent_dirty_i | input | N | Entry dirty flags |
| match_o | output | N | Raw per-entry match vector |
| hit_o | output | 1 | Exactly one entry matches |
| hit_idx_o | output | IDX_W | Position of the single matching entry |
| pa_o | output | PA_W | Physical address |
| perm_o | output | 3 | {execute, write, read} |
| fault_o | output | 12 | Fault code, 0 when none |

## Verification
The bench builds the block with N = 6. The index is then three bits wide and has two unused codes, so an index leak or a select-mux fault past the power-of-two boundary becomes visible. Six entries also leave room for one large page to overlap several small ones in the same vector, which tests the multiple-hit path. The default tag width of 8 and physical width of 29 are kept. The random entries use a narrow tag range and cluster their page numbers, so every page size, tag case and fault class comes up often.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
  localparam int VA_W     = 32;
  localparam int PAGE_LSB = 10;
  localparam int VPN_W    = VA_W - PAGE_LSB;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_e;

  localparam logic [11:0] FLT_NONE     = 12'h000;
  localparam logic [11:0] FLT_MISS_RD  = 12'h040;
  localparam logic [11:0] FLT_MISS_WR  = 12'h060;
  localparam logic [11:0] FLT_FIRST_WR = 12'h080;
  localparam logic [11:0] FLT_PROT_RD  = 12'h0A0;
  localparam logic [11:0] FLT_PROT_WR  = 12'h0C0;
  localparam logic [11:0] FLT_MULTI    = 12'h140;

  // number of in-page offset bits for a size code
  function automatic int off_bits(logic [1:0] sz);
    case (sz)
      2'd0:    return 10;
      2'd1:    return 12;
      2'd2:    return 16;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/tlbc_entry_match.sv
module tlbc_entry_match
  import tlbc_pkg::*;
#(
  parameter int ASID_W = 8
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              asid_chk_en_i,
  input  logic              valid_i,
  input  logic              shared_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [1:0]        size_i,
  output logic              match_o
);
  logic [VA_W-1:0] base;
  logic [VA_W-1:0] off_mask;
  logic            addr_hit;
  logic            tag_ok;

  assign base = {vpn_i, {PAGE_LSB{1'b0}}};

  always_comb begin
    for (int b = 0; b < VA_W; b++) off_mask[b] = (b < off_bits(size_i));
  end

  assign addr_hit = (((va_i ^ base) & ~off_mask) == '0);
  assign tag_ok   = shared_i || !asid_chk_en_i || (asid_i == cur_asid_i);
  assign match_o  = valid_i && tag_ok && addr_hit;
endmodule

// File: rtl/tlbc_hit_select.sv
module tlbc_hit_select #(
  parameter  int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     match_i,
  output logic             hit_o,
  output logic             multi_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             seen;
  logic [IDX_W-1:0] idx_or;

  // running "already seen one" chain flags the second match
  always_comb begin
    seen    = 1'b0;
    multi_o = 1'b0;
    idx_or  = '0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i]) begin
        if (seen) multi_o = 1'b1;
        seen   = 1'b1;
        idx_or = idx_or | IDX_W'(i);
      end
    end
  end

  assign hit_o = seen && !multi_o;
  assign idx_o = hit_o ? idx_or : '0;
endmodule

// File: rtl/tlbc_fault_decode.sv
module tlbc_fault_decode
  import tlbc_pkg::*;
#(
  parameter  int PA_W  = 29,
  localparam int PPN_W = PA_W - PAGE_LSB
) (
  input  logic [1:0]       acc_i,
  input  logic             priv_i,
  input  logic             hit_i,
  input  logic             multi_i,
  input  logic [1:0]       prot_i,
  input  logic             dirty_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [1:0]       size_i,
  input  logic [PA_W-1:0]  va_low_i,
  output logic [PA_W-1:0]  pa_o,
  output logic [2:0]       perm_o,
  output logic [11:0]      fault_o
);
  logic            is_wr;
  logic [PA_W-1:0] off_mask;
  logic [PA_W-1:0] pa_raw;

  assign is_wr = (acc_i == ACC_WRITE);

  always_comb begin
    for (int b = 0; b < PA_W; b++) off_mask[b] = (b < off_bits(size_i));
  end

  assign pa_raw = ({ppn_i, {PAGE_LSB{1'b0}}} & ~off_mask) | (va_low_i & off_mask);

  // priority: multi, miss, user protection, write protect, clean page
  always_comb begin
    if (multi_i)                     fault_o = FLT_MULTI;
    else if (!hit_i)                 fault_o = is_wr ? FLT_MISS_WR : FLT_MISS_RD;
    else if (!priv_i && !prot_i[1])  fault_o = is_wr ? FLT_PROT_WR : FLT_PROT_RD;
    else if (is_wr && !prot_i[0])    fault_o = FLT_PROT_WR;
    else if (is_wr && !dirty_i)      fault_o = FLT_FIRST_WR;
    else                             fault_o = FLT_NONE;
  end

  always_comb begin
    if (fault_o == FLT_NONE) begin
      pa_o   = pa_raw;
      perm_o = {acc_i == ACC_FETCH, prot_i[0] && dirty_i, 1'b1};
    end else begin
      pa_o   = '0;
      perm_o = '0;
    end
  end
endmodule

// File: rtl/tlbc_lookup.sv
module tlbc_lookup
  import tlbc_pkg::*;
#(
  parameter  int N      = 4,
  parameter  int ASID_W = 8,
  parameter  int PA_W   = 29,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int PPN_W  = PA_W - PAGE_LSB
) (
  input  logic [1:0]                  acc_i,
  input  logic [VA_W-1:0]             va_i,
  input  logic [ASID_W-1:0]           cur_asid_i,
  input  logic                        priv_i,
  input  logic                        sv_mode_i,
  input  logic [N-1:0]                ent_valid_i,
  input  logic [N-1:0]                ent_shared_i,
  input  logic [N-1:0][ASID_W-1:0]    ent_asid_i,
  input  logic [N-1:0][VPN_W-1:0]     ent_vpn_i,
  input  logic [N-1:0][PPN_W-1:0]     ent_ppn_i,
  input  logic [N-1:0][1:0]           ent_size_i,
  input  logic [N-1:0][1:0]           ent_prot_i,
  input  logic [N-1:0]                ent_dirty_i,
  output logic [N-1:0]                match_o,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            hit_idx_o,
  output logic [PA_W-1:0]             pa_o,
  output logic [2:0]                  perm_o,
  output logic [11:0]                 fault_o
);
  logic asid_chk_en;
  logic multi;

  assign asid_chk_en = !(sv_mode_i && priv_i);

  for (genvar g = 0; g < N; g++) begin : g_ent
    tlbc_entry_match #(.ASID_W(ASID_W)) u_match (
      .va_i          (va_i),
      .cur_asid_i    (cur_asid_i),
      .asid_chk_en_i (asid_chk_en),
      .valid_i       (ent_valid_i[g]),
      .shared_i      (ent_shared_i[g]),
      .asid_i        (ent_asid_i[g]),
      .vpn_i         (ent_vpn_i[g]),
      .size_i        (ent_size_i[g]),
      .match_o       (match_o[g])
    );
  end

  tlbc_hit_select #(.N(N)) u_sel (
    .match_i (match_o),
    .hit_o   (hit_o),
    .multi_o (multi),
    .idx_o   (hit_idx_o)
  );

  tlbc_fault_decode #(.PA_W(PA_W)) u_dec (
    .acc_i    (acc_i),
    .priv_i   (priv_i),
    .hit_i    (hit_o),
    .multi_i  (multi),
    .prot_i   (ent_prot_i[hit_idx_o]),
    .dirty_i  (ent_dirty_i[hit_idx_o]),
    .ppn_i    (ent_ppn_i[hit_idx_o]),
    .size_i   (ent_size_i[hit_idx_o]),
    .va_low_i (va_i[PA_W-1:0]),
    .pa_o     (pa_o),
    .perm_o   (perm_o),
    .fault_o  (fault_o)
  );
endmodule

// File: rtl/tlbc_lookup_chk.sv
module tlbc_lookup_chk #(
  parameter  int N      = 4,
  parameter  int PA_W   = 29,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input logic [1:0]       acc_i,
  input logic             priv_i,
  input logic [N-1:0][1:0] ent_prot_i,
  input logic [N-1:0]     ent_dirty_i,
  input logic [N-1:0]     match_o,
  input logic             hit_o,
  input logic [IDX_W-1:0] hit_idx_o,
  input logic [PA_W-1:0]  pa_o,
  input logic [2:0]       perm_o,
  input logic [11:0]      fault_o
);
  always_comb begin
    a_r4_multi_code: assert (!($countones(match_o) > 1) || fault_o == 12'h140)
      else $error("multi-hit without 0x140");
    a_r6_miss_code: assert (match_o != '0 ||
                            fault_o == ((acc_i == 2'b01) ? 12'h060 : 12'h040))
      else $error("miss code wrong");
    a_r10_fault_clears: assert (fault_o == 12'h000 || (pa_o == '0 && perm_o == 3'b000))
      else $error("fault with live pa/perm");
    a_r10_hit_single: assert (hit_o == ($countones(match_o) == 1))
      else $error("hit_o disagrees with match count");
    a_r10_idx_points: assert (!hit_o || match_o[hit_idx_o])
      else $error("hit index not on a matching entry");
    a_r7_user_bit1: assert (!(hit_o && fault_o == 12'h000 && !priv_i) ||
                            ent_prot_i[hit_idx_o][1])
      else $error("user access allowed without protection bit 1");
    a_r8_write_ok: assert (!(hit_o && fault_o == 12'h000 && acc_i == 2'b01) ||
                           (ent_prot_i[hit_idx_o][0] && ent_dirty_i[hit_idx_o]))
      else $error("write allowed on protected or clean page");
    a_r9_write_perm: assert (!perm_o[1] ||
                             (hit_o && ent_prot_i[hit_idx_o][0] && ent_dirty_i[hit_idx_o]))
      else $error("write permission without bit 0 and dirty");
  end
endmodule

bind tlbc_lookup tlbc_lookup_chk #(.N(N), .PA_W(PA_W)) u_chk (
  .acc_i       (acc_i),
  .priv_i      (priv_i),
  .ent_prot_i  (ent_prot_i),
  .ent_dirty_i (ent_dirty_i),
  .match_o     (match_o),
  .hit_o       (hit_o),
  .hit_idx_o   (hit_idx_o),
  .pa_o        (pa_o),
  .perm_o      (perm_o),
  .fault_o     (fault_o)
);

// File: tb/tlbc_lookup_test.sv
module tlbc_lookup_test;
  localparam int N      = 6;
  localparam int ASID_W = 8;
  localparam int PA_W   = 29;
  localparam int IDX_W  = 3;
  localparam int PPN_W  = PA_W - 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]               acc;
  logic [31:0]              va;
  logic [ASID_W-1:0]        cur_asid;
  logic                     priv, sv;
  logic [N-1:0]             e_v, e_sh, e_d;
  logic [N-1:0][ASID_W-1:0] e_asid;
  logic [N-1:0][21:0]       e_vpn;
  logic [N-1:0][PPN_W-1:0]  e_ppn;
  logic [N-1:0][1:0]        e_sz, e_pr;

  logic [N-1:0]     match;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [PA_W-1:0]  pa;
  logic [2:0]       perm;
  logic [11:0]      fault;

  tlbc_lookup #(.N(N), .ASID_W(ASID_W), .PA_W(PA_W)) uut (
    .acc_i(acc), .va_i(va), .cur_asid_i(cur_asid), .priv_i(priv), .sv_mode_i(sv),
    .ent_valid_i(e_v), .ent_shared_i(e_sh), .ent_asid_i(e_asid), .ent_vpn_i(e_vpn),
    .ent_ppn_i(e_ppn), .ent_size_i(e_sz), .ent_prot_i(e_pr), .ent_dirty_i(e_d),
    .match_o(match), .hit_o(hit), .hit_idx_o(hit_idx), .pa_o(pa), .perm_o(perm),
    .fault_o(fault)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R10";

  logic [N-1:0]     x_match;
  logic             x_hit;
  logic [IDX_W-1:0] x_idx;
  logic [PA_W-1:0]  x_pa;
  logic [2:0]       x_perm;
  logic [11:0]      x_fault;

  task automatic model();
    bit tag_chk = !(sv && priv);
    int cnt = 0;
    int k = 0;
    longint unsigned a = va;
    x_match = '0;
    for (int i = 0; i < N; i++) begin
      int sh = (e_sz[i] == 0) ? 10 : (e_sz[i] == 1) ? 12 : (e_sz[i] == 2) ? 16 : 20;
      longint unsigned b = longint'(e_vpn[i]) * 1024;
      if (e_v[i] && (e_sh[i] || !tag_chk || e_asid[i] == cur_asid) && ((a >> sh) == (b >> sh))) begin
        cnt++;
        k = i;
        x_match[i] = 1'b1;
      end
    end
    x_hit = (cnt == 1);
    x_idx = x_hit ? IDX_W'(k) : '0;
    x_pa = '0;
    x_perm = '0;
    if (cnt > 1) x_fault = 12'h140;
    else if (cnt == 0) x_fault = (acc == 2'b01) ? 12'h060 : 12'h040;
    else if (!priv && !e_pr[k][1]) x_fault = (acc == 2'b01) ? 12'h0C0 : 12'h0A0;
    else if (acc == 2'b01 && !e_pr[k][0]) x_fault = 12'h0C0;
    else if (acc == 2'b01 && !e_d[k]) x_fault = 12'h080;
    else begin
      int sh = (e_sz[k] == 0) ? 10 : (e_sz[k] == 1) ? 12 : (e_sz[k] == 2) ? 16 : 20;
      longint unsigned pg = (longint'(e_ppn[k]) * 1024) >> sh << sh;
      longint unsigned off = a % (longint'(1) << sh);
      x_fault = 12'h000;
      x_pa = PA_W'(pg | off);
      x_perm = {acc == 2'b10, e_pr[k][0] && e_d[k], 1'b1};
    end
  endtask

  task automatic check_all();
    model();
    n_cmp++;
    if (match !== x_match || hit !== x_hit || hit_idx !== x_idx || pa !== x_pa ||
        perm !== x_perm || fault !== x_fault) begin
      n_bad++;
      $display("FAIL %s: match=%b hit=%b idx=%0d pa=%h perm=%b fault=%h expected match=%b hit=%b idx=%0d pa=%h perm=%b fault=%h",
               tag, match, hit, hit_idx, pa, perm, fault,
               x_match, x_hit, x_idx, x_pa, x_perm, x_fault);
    end
  endtask

  // compare on every falling edge; stimulus changes right after it
  always @(negedge clk) if (rst_ni) check_all();

  task automatic step(string t);
    tag = t;
    @(negedge clk);
    #1;
  endtask

  task automatic clear_all();
    e_v = '0; e_sh = '0; e_d = '0; e_asid = '0; e_vpn = '0;
    e_ppn = '0; e_sz = '0; e_pr = '0;
  endtask

  task automatic put(int i, bit sh, int tg, int vpn, int ppn, int sz, int pr, bit d);
    e_v[i] = 1'b1; e_sh[i] = sh; e_asid[i] = ASID_W'(tg); e_vpn[i] = 22'(vpn);
    e_ppn[i] = PPN_W'(ppn); e_sz[i] = 2'(sz); e_pr[i] = 2'(pr); e_d[i] = d;
  endtask

  task automatic rand_vec();
    cur_asid = ASID_W'($urandom % 4);
    priv = 1'($urandom); sv = 1'($urandom); acc = 2'($urandom % 3);
    for (int i = 0; i < N; i++) begin
      e_v[i] = ($urandom % 4) != 0;
      e_sh[i] = ($urandom % 4) == 0;
      e_asid[i] = ASID_W'($urandom % 4);
      e_vpn[i] = 22'((($urandom % 4) << 10) | ($urandom & 32'h3FF));
      e_ppn[i] = PPN_W'($urandom);
      e_sz[i] = 2'($urandom); e_pr[i] = 2'($urandom); e_d[i] = 1'($urandom);
    end
    va = (($urandom % 4) << 20) | ($urandom & 32'hFFFFF);
    if ($urandom % 2 == 1) begin
      int k = $urandom % N;
      va = {e_vpn[k], 10'($urandom)};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_all();
    acc = 2'b00; va = 32'h1234_5678; cur_asid = '0; priv = 1'b1; sv = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    step("R6 reset-empty read miss");
    acc = 2'b01; step("R6 write miss");
    acc = 2'b10; step("R6 fetch miss");

    // R1 page sizes: 1 MB, 1 KB, 64 KB (low VPN bits ignored), 4 KB
    acc = 2'b00;
    put(0, 1'b1, 0, 32'h0030_0000 >> 10, 32'h1_2345, 3, 3, 1'b1);
    va = 32'h003F_FFFC; step("R1 1MB top of page, R5");
    va = 32'h0040_0000; step("R1 1MB just past page");
    clear_all();
    put(1, 1'b1, 0, 32'h0010_0400 >> 10, 32'h0_0ABC, 0, 3, 1'b1);
    va = 32'h0010_07FF; step("R1 1KB last byte, R5");
    va = 32'h0010_0800; step("R1 1KB next page");
    va = 32'h0010_03FF; step("R1 1KB previous page");
    clear_all();
    put(5, 1'b1, 0, 32'h0803_0C00 >> 10, 32'h1_2345, 2, 3, 1'b1);
    va = 32'h0803_0000; step("R1 64KB base below vpn, R5");
    va = 32'h0803_FFFF; step("R1 64KB top, R10 idx 5");
    clear_all();
    put(3, 1'b1, 0, 32'h0000_5000 >> 10, 32'h7_FFFF, 1, 3, 1'b1);
    va = 32'h0000_5FFF; step("R1 4KB top, R5");
    e_v[3] = 1'b0; step("R1 invalid entry ignored");

    // R2/R3 tag rules
    clear_all();
    put(2, 1'b0, 5, 32'h0000_8000 >> 10, 32'h100, 1, 3, 1'b1);
    va = 32'h0000_8010; cur_asid = 8'd5; priv = 1'b0; sv = 1'b0;
    step("R2 tag equal hits");
    cur_asid = 8'd6; step("R2 tag differs misses");
    e_sh[2] = 1'b1; step("R2 shared ignores tag");
    e_sh[2] = 1'b0; sv = 1'b1; priv = 1'b1; step("R3 sv+priv disables tag check");
    priv = 1'b0; step("R3 sv+user keeps tag check");
    sv = 1'b0; priv = 1'b1; step("R3 priv alone keeps tag check");

    // R4 overlap
    clear_all(); cur_asid = '0; priv = 1'b1;
    put(0, 1'b1, 0, 32'h0020_0000 >> 10, 1, 3, 3, 1'b1);
    put(4, 1'b1, 0, 32'h0024_0000 >> 10, 2, 1, 3, 1'b1);
    va = 32'h0024_0100; step("R4 two entries overlap");
    put(5, 1'b1, 0, 32'h0024_0000 >> 10, 3, 0, 3, 1'b1);
    step("R4 three entries overlap");
    va = 32'h0030_0000; step("R4 outside overlap misses");
    va = 32'h0021_0000; step("R10 single hit among overlapping set");

    // R7/R8/R9 protection order
    clear_all();
    put(1, 1'b1, 0, 32'h0000_4000 >> 10, 32'h55, 1, 0, 1'b0);
    va = 32'h0000_4004; priv = 1'b0;
    acc = 2'b00; step("R7 user read bit1 clear");
    acc = 2'b10; step("R7 user fetch bit1 clear");
    acc = 2'b01; step("R7 user write bit1 clear");
    e_pr[1] = 2'b01; step("R7 user violation before clean check");
    priv = 1'b1; e_pr[1] = 2'b00; acc = 2'b00; step("R9 priv read bit1 clear ok");
    acc = 2'b01; e_pr[1] = 2'b10; step("R8 write protect before clean");
    e_pr[1] = 2'b11; step("R8 clean page first write");
    e_d[1] = 1'b1; step("R9 write granted");
    acc = 2'b10; step("R9 fetch exec perm");
    e_pr[1] = 2'b10; acc = 2'b00; step("R9 read no write perm");
    priv = 1'b0; e_pr[1] = 2'b10; acc = 2'b10; step("R9 user fetch with bit1");

    for (int r = 0; r < 3000; r++) begin
      rand_vec();
      step("R1-random lookup");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule